// File: doc/BRIEF.md
# Selector-Based Segment Translator with Bounds and Access Checking

This block turns a segment selector and a byte offset into a physical address. The selector does not carry an address itself. It picks one slot in a small on-chip descriptor table. Each slot records where the segment starts (its base), the largest offset the segment allows (its limit), which kinds of access it permits, and whether it is present at all.

Software loads the table through a simple write port, one slot per cycle. The address pipeline then presents one request per cycle: a selector, an access kind and an offset. One cycle later the block answers in one of two ways. Either it drives a valid physical address equal to base plus offset, or it pulses a fault line with a cause code that says why the access was refused. Fetching descriptors from main memory, paging and the fault handler are outside this block.

Top module: `segx_xlate`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), and after it is released with no further writes, addr_valid and fault_pulse are low, fault_cause is 0, addr_out is 0, and every table slot is marked absent.
- R2: A cycle with cfg_we high stores cfg_base, cfg_limit, cfg_perm and cfg_present into slot cfg_idx. Requests from the next cycle onward see the new contents. A request in the same cycle as the write sees the old contents.
- R3: A request sampled at a clock edge with req_valid high is answered on the outputs right after that edge, and a new request may be accepted on every edge. A cycle with req_valid low produces addr_valid low, fault_pulse low, fault_cause 0 and addr_out 0.
- R4: If the slot is present, the offset is in range and the access is permitted, addr_valid goes high, fault_pulse stays low, fault_cause is 0, and addr_out equals base + offset truncated to 32 bits.
- R5: A request to a slot with present clear faults with fault_cause 1.
- R6: The limit is the largest valid offset, inclusive. An offset greater than the zero-extended 20-bit limit faults with fault_cause 2, so any offset of 2^20 or above always faults.
- R7: req_kind 0 is read, 1 is write, 2 is execute and 3 is reserved. The kinds 0, 1 and 2 are granted by cfg_perm bit 0, bit 1 and bit 2 in that order. Reserved is never granted. A refused kind faults with fault_cause 3.
- R8: When several checks fail, the reported cause is absent (1) first, then range (2), then permission (3).
- R9: A faulting request drives fault_pulse high for exactly the one answer cycle, with addr_valid low and addr_out 0. fault_cause is nonzero only while fault_pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 3 | Slot to write |
| cfg_base | input | 32 | Segment start address to store |
| cfg_limit | input | 20 | Largest valid offset to store |
| cfg_perm | input | 3 | Access grants: bit 0 read, bit 1 write, bit 2 execute |
| cfg_present | input | 1 | Present flag to store |
| req_valid | input | 1 | Request strobe |
| req_sel | input | 3 | Selector (slot index) |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| req_off | input | 32 | Byte offset within the segment |
| addr_valid | output | 1 | Translated address is valid this cycle |
| addr_out | output | 32 | Physical address, 0 when not valid |
| fault_pulse | output | 1 | Request refused this cycle |
| fault_cause | output | 2 | 0 none, 1 absent, 2 range, 3 permission |

## Verification
The assertions assume that rst_n is held low long enough to clear the pipeline. They also assume req_valid, req_kind and req_off are settled before each sampling edge, because the checks compare the answer with the request one cycle earlier. The stimulus drives every input on the falling edge and holds req_valid low during reset. It sweeps every slot, every access kind and offsets at zero, at the limit, just past it, at mid-range and far past the 20-bit range. The table contents are chosen so that absent slots, zero limits, empty grants and a wrapping base all meet each offset.

// File: rtl/segx_pkg.sv
package segx_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_ABSENT = 2'd1,
        CAUSE_RANGE  = 2'd2,
        CAUSE_ACCESS = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic ex;
        logic wr;
        logic rd;
    } perm_t;

endpackage

// File: rtl/segx_desc_table.sv
module segx_desc_table
    import segx_pkg::*;
#(
    parameter int N      = 8,
    parameter int BASE_W = 32,
    parameter int LIM_W  = 20,
    parameter int SEL_W  = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_idx,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  perm_t             wr_perm,
    input  logic              wr_present,
    input  logic [SEL_W-1:0]  rd_idx,
    output logic [BASE_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    output perm_t             rd_perm,
    output logic              rd_present
);

    typedef struct packed {
        logic              present;
        perm_t             perm;
        logic [LIM_W-1:0]  lim;
        logic [BASE_W-1:0] base;
    } ent_t;

    ent_t rows [N];

    for (genvar i = 0; i < N; i++) begin : g_slot
        ent_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == SEL_W'(i))) begin
                ent_d.present = wr_present;
                ent_d.perm    = wr_perm;
                ent_d.lim     = wr_limit;
                ent_d.base    = wr_base;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign rows[i] = ent_q;
    end

    ent_t pick;
    assign pick       = rows[rd_idx];
    assign rd_base    = pick.base;
    assign rd_limit   = pick.lim;
    assign rd_perm    = pick.perm;
    assign rd_present = pick.present;

endmodule

// File: rtl/segx_eval.sv
module segx_eval
    import segx_pkg::*;
#(
    parameter int BASE_W = 32,
    parameter int LIM_W  = 20,
    parameter int OFF_W  = 32,
    parameter int ADDR_W = 32
) (
    input  logic              present,
    input  logic [BASE_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    input  perm_t             perm,
    input  logic [1:0]        kind,
    input  logic [OFF_W-1:0]  off,
    output cause_e            cause,
    output logic [ADDR_W-1:0] sum
);

    logic over;
    logic granted;

    always_comb begin
        over = (off > OFF_W'(limit));
        case (kind)
            ACC_READ:  granted = perm.rd;
            ACC_WRITE: granted = perm.wr;
            ACC_EXEC:  granted = perm.ex;
            default:   granted = 1'b0;
        endcase
        if (!present)     cause = CAUSE_ABSENT;
        else if (over)    cause = CAUSE_RANGE;
        else if (!granted) cause = CAUSE_ACCESS;
        else              cause = CAUSE_NONE;
        sum = ADDR_W'(base) + ADDR_W'(off);
    end

endmodule

// File: rtl/segx_xlate.sv
module segx_xlate
    import segx_pkg::*;
#(
    parameter int N      = 8,
    parameter int BASE_W = 32,
    parameter int LIM_W  = 20,
    parameter int OFF_W  = 32,
    parameter int ADDR_W = 32,
    parameter int SEL_W  = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_idx,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [LIM_W-1:0]  cfg_limit,
    input  logic [2:0]        cfg_perm,
    input  logic              cfg_present,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [1:0]        req_kind,
    input  logic [OFF_W-1:0]  req_off,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr_out,
    output logic              fault_pulse,
    output logic [1:0]        fault_cause
);

    typedef struct packed {
        logic              vld;
        logic              flt;
        cause_e            cause;
        logic [ADDR_W-1:0] addr;
    } out_t;

    logic [BASE_W-1:0] d_base;
    logic [LIM_W-1:0]  d_limit;
    perm_t             d_perm;
    logic              d_present;
    cause_e            verdict;
    logic [ADDR_W-1:0] phys;

    segx_desc_table #(
        .N(N), .BASE_W(BASE_W), .LIM_W(LIM_W), .SEL_W(SEL_W)
    ) u_tab (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_idx     (cfg_idx),
        .wr_base    (cfg_base),
        .wr_limit   (cfg_limit),
        .wr_perm    (perm_t'(cfg_perm)),
        .wr_present (cfg_present),
        .rd_idx     (req_sel),
        .rd_base    (d_base),
        .rd_limit   (d_limit),
        .rd_perm    (d_perm),
        .rd_present (d_present)
    );

    segx_eval #(
        .BASE_W(BASE_W), .LIM_W(LIM_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
    ) u_eval (
        .present (d_present),
        .base    (d_base),
        .limit   (d_limit),
        .perm    (d_perm),
        .kind    (req_kind),
        .off     (req_off),
        .cause   (verdict),
        .sum     (phys)
    );

    out_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (req_valid) begin
            if (verdict == CAUSE_NONE) begin
                st_d.vld  = 1'b1;
                st_d.addr = phys;
            end else begin
                st_d.flt   = 1'b1;
                st_d.cause = verdict;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_valid  = st_q.vld;
    assign addr_out    = st_q.addr;
    assign fault_pulse = st_q.flt;
    assign fault_cause = st_q.cause;

endmodule

// File: rtl/segx_xlate_chk.sv
module segx_xlate_chk #(
    parameter int SEL_W  = 3,
    parameter int LIM_W  = 20,
    parameter int OFF_W  = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [OFF_W-1:0]  req_off,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] addr_out,
    input logic              fault_pulse,
    input logic [1:0]        fault_cause
);

    // R9
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_valid && fault_pulse));

    // R9
    cause_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> (fault_cause != 2'd0));

    // R9
    cause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_pulse |-> (fault_cause == 2'd0));

    // R9
    addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> (addr_out == '0));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!addr_valid && !fault_pulse));

    // R7
    rsvd_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |=> fault_pulse);

    // R6
    wide_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (($past(req_off) >> LIM_W) == '0));

endmodule

bind segx_xlate segx_xlate_chk #(
    .SEL_W(SEL_W), .LIM_W(LIM_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_off     (req_off),
    .addr_valid  (addr_valid),
    .addr_out    (addr_out),
    .fault_pulse (fault_pulse),
    .fault_cause (fault_cause)
);

// File: tb/sim_segx_xlate.sv
module sim_segx_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0;
    logic [19:0] cfg_limit = '0;
    logic [2:0]  cfg_perm = '0;
    logic        cfg_present = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_sel = '0;
    logic [1:0]  req_kind = '0;
    logic [31:0] req_off = '0;
    logic        addr_valid;
    logic [31:0] addr_out;
    logic        fault_pulse;
    logic [1:0]  fault_cause;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_base [8];
    logic [19:0] m_lim  [8];
    logic [2:0]  m_perm [8];
    logic        m_pres [8];

    always #10 clk = ~clk;

    segx_xlate u0 (.*);

    function automatic logic [31:0] slot_base(int i);
        return (i == 7) ? 32'hFFFF_FF00 : (32'h0100_0000 * i + 32'h10 * i);
    endfunction
    function automatic logic [19:0] slot_lim(int i);
        if (i == 3) return 20'h0;
        if (i == 6) return 20'hFFFFF;
        return 20'(20'h00FF0 * i + 20'h0F);
    endfunction
    function automatic logic [2:0] slot_perm(int i);
        return (i == 7) ? 3'b111 : 3'((i * 5 + 1) & 7);
    endfunction

    task automatic write_slot(int i, logic [31:0] b, logic [19:0] l, logic [2:0] p, logic pr);
        cfg_we = 1'b1; cfg_idx = 3'(i); cfg_base = b; cfg_limit = l;
        cfg_perm = p; cfg_present = pr;
        m_base[i] = b; m_lim[i] = l; m_perm[i] = p; m_pres[i] = pr;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic compare(string tag, logic ev, logic ef, logic [1:0] ec, logic [31:0] ea);
        n_cmp++;
        if (addr_valid !== ev || fault_pulse !== ef || fault_cause !== ec || addr_out !== ea) begin
            n_bad++;
            $display("FAIL %s: actual v=%0b f=%0b c=%0d a=%h expected v=%0b f=%0b c=%0d a=%h",
                     tag, addr_valid, fault_pulse, fault_cause, addr_out, ev, ef, ec, ea);
        end
    endtask

    // Model of R4..R8 from the written table contents.
    task automatic send_check(int s, int k, logic [31:0] o, string extra);
        logic [1:0]  ec;
        logic [31:0] ea;
        string       tag;
        req_valid = 1'b1; req_sel = 3'(s); req_kind = 2'(k); req_off = o;
        if (!m_pres[s])                   ec = 2'd1;
        else if (o > {12'h0, m_lim[s]})   ec = 2'd2;
        else if (k == 3 || !m_perm[s][k]) ec = 2'd3;
        else                              ec = 2'd0;
        ea = (ec == 0) ? (m_base[s] + o) : 32'h0;
        case (ec)
            2'd0: tag = "R4";
            2'd1: tag = "R5/R8";
            2'd2: tag = "R6/R8/R9";
            default: tag = "R7/R9";
        endcase
        @(negedge clk);
        compare({tag, extra}, ec == 0, ec != 0, ec, ea);
    endtask

    task automatic idle_check();
        req_valid = 1'b0; req_off = 32'hDEAD_BEEF;
        @(negedge clk);
        compare("R3 idle", 1'b0, 1'b0, 2'd0, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_base[i] = '0; m_lim[i] = '0; m_perm[i] = '0; m_pres[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        compare("R1 in reset", 1'b0, 1'b0, 2'd0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release", 1'b0, 1'b0, 2'd0, 32'h0);
        // R1: every slot absent after reset
        for (int s = 0; s < 8; s++) send_check(s, 0, 32'h0, " R1 absent");

        for (int i = 0; i < 8; i++)
            write_slot(i, slot_base(i), slot_lim(i), slot_perm(i), i != 5);

        // Sweep: every slot, kind and offset class, back to back (R3)
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 4; k++) begin
                logic [31:0] lim;
                lim = {12'h0, m_lim[s]};
                send_check(s, k, 32'h0, " sweep");
                send_check(s, k, lim, " sweep at limit");
                send_check(s, k, lim + 1, " sweep past limit");
                send_check(s, k, lim >> 1, " sweep mid");
                send_check(s, k, 32'h0010_0000, " sweep wide R6");
                send_check(s, k, 32'hFFFF_FFFF, " sweep max");
            end
        end

        // R9: fault pulse lasts one cycle
        send_check(5, 0, 32'h0, " R9 pulse");
        idle_check();

        // R2: same-cycle write and request sees old slot 1 (write granted)
        cfg_we = 1'b1; cfg_idx = 3'd1; cfg_base = 32'h0; cfg_limit = 20'h0;
        cfg_perm = 3'b000; cfg_present = 1'b0;
        send_check(1, 1, 32'h20, " R2 old contents");
        cfg_we = 1'b0;
        m_base[1] = 32'h0; m_lim[1] = 20'h0; m_perm[1] = 3'b000; m_pres[1] = 1'b0;
        send_check(1, 1, 32'h20, " R2 new contents");

        // R2: rewrite slot 2 and use it next cycle
        write_slot(2, 32'h8000_0000, 20'h00010, 3'b100, 1'b1);
        send_check(2, 2, 32'h10, " R2 rewrite");
        send_check(2, 0, 32'h10, " R2 rewrite perm");
        idle_check();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R3 watchdog: actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule